// File: doc/BRIEF.md
# Chained Interrupt Priority Responder

This block sits between four local interrupt sources and a CPU bus that uses a serial priority chain. Each source raises a one-cycle request pulse, which the block latches as pending. Among the pending channels the lowest-numbered one wins. The block pulls an active-low request line toward the CPU whenever it holds the chain's right to interrupt. When the CPU runs an acknowledge cycle, the block drives an 8-bit vector onto the data bus. The vector is a programmed byte with the winning channel number inserted into bits 2:1 and bit 0 forced to zero.

Priority is passed along the chain through an enable input and an enable output. A device drives its enable output low to mute every device further from the CPU. It does so while it is servicing a channel or holding an unacknowledged request. An acknowledged channel moves from pending to in-service. While a channel is in service, it blocks itself and every lower-priority local channel. Higher-priority local channels can still interrupt, so service nests. The block watches opcode fetches on the data bus. When two consecutive fetches carry the return-from-interrupt pair ED then 4D, it ends service of the highest-priority channel currently in service.

Top module: `irq_chain_responder`

## Requirements
- R1: When several eligible channels are pending at once, the acknowledge vector carries the lowest channel number; channel 0 outranks channel 3.
- R2: While `ie_i` is low, `int_n_o` stays high, `ie_o` is low, and an acknowledge cycle gets no vector (`data_oe_o` low).
- R3: `int_n_o` is low exactly when `ie_i` is high and at least one pending channel is not blocked by an in-service channel of equal or higher priority.
- R4: An acknowledge cycle is a cycle with `m1_n_i` and `iorq_n_i` both low. `data_oe_o` is high only during such a cycle, and only if a request was eligible when the cycle began.
- R5: The vector is `{vec[7:3], ch[1:0], 1'b0}`, where `vec` is the programmed byte and `ch` is the winning channel. A programmed 0x38 with channel 3 gives 0x3E.
- R6: `ie_o` is low while any local channel is in service, and low while a channel is pending outside an acknowledge cycle. It is also low during an acknowledge cycle in which this block responds.
- R7: After an acknowledge, the winning channel becomes in-service and its pending flag clears. Channels of equal or lower priority cannot request until its service ends.
- R8: While a channel is in service, a higher-priority channel can still request and be acknowledged (nesting).
- R9: An opcode fetch (`m1_n_i` low, `iorq_n_i` high) of 0xED, followed by a fetch of 0x4D as the next fetch, ends service of the lowest-numbered in-service channel.
- R10: A fetch of 0xED followed by a fetch of any other byte ends no service, even if 0x4D comes in a later fetch.
- R11: A cycle with `vec_we_i` high stores `vec_wdata_i` as the vector byte. Bits 2:0 of the stored byte never reach the bus.
- R12: After reset, nothing is pending or in service, the vector byte is zero, `int_n_o` is high and `data_oe_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | NUM_CH | One-cycle request pulses, one per channel |
| vec_we_i | input | 1 | Vector byte write strobe |
| vec_wdata_i | input | 8 | Vector byte to store |
| ie_i | input | 1 | Chain enable from the higher-priority side |
| ie_o | output | 1 | Chain enable to the lower-priority side |
| int_n_o | output | 1 | Active-low interrupt request to the CPU |
| m1_n_i | input | 1 | Active-low machine-cycle-one strobe |
| iorq_n_i | input | 1 | Active-low I/O request strobe |
| data_i | input | 8 | Data bus as seen by the block (opcode fetches) |
| data_o | output | 8 | Vector driven during acknowledge |
| data_oe_o | output | 1 | Drive enable for `data_o` |

## Verification
The bench builds the block with the default of four channels. With four channels the 2-bit channel field in bits 2:1 takes all four codes, so every vector code can be checked against the expected byte. Channel 3 is the only one that sets both field bits. Four channels also allow a three-level nesting sequence (channel 0 over channel 1, with channel 2 blocked behind both). The bench checks how pending and in-service state unwind as each return sequence is decoded.

// File: rtl/irq_chain_pkg.sv
package irq_chain_pkg;
   localparam int unsigned BUS_W = 8;
   localparam logic [BUS_W-1:0] OPC_PREFIX = 8'hED;
   localparam logic [BUS_W-1:0] OPC_RETURN = 8'h4D;
endpackage

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
   parameter int unsigned N  = 4,
   parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  cand_i,
   output logic          any_o,
   output logic [IW-1:0] idx_o,
   output logic [N-1:0]  onehot_o
);
   always_comb begin
      any_o    = |cand_i;
      idx_o    = '0;
      onehot_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (cand_i[i]) begin
            idx_o    = IW'(i);
            onehot_o = N'(1) << i;
         end
      end
   end
endmodule

// File: rtl/irq_chan_track.sv
module irq_chan_track #(
   parameter int unsigned N = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] req_i,
   input  logic [N-1:0] grant_i,
   input  logic [N-1:0] done_i,
   output logic [N-1:0] pend_o,
   output logic [N-1:0] svc_o
);
   for (genvar g = 0; g < N; g++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_o[g] <= 1'b0;
            svc_o[g]  <= 1'b0;
         end else begin
            if (grant_i[g])      pend_o[g] <= 1'b0;
            else if (req_i[g])   pend_o[g] <= 1'b1;
            if (grant_i[g])      svc_o[g]  <= 1'b1;
            else if (done_i[g])  svc_o[g]  <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/irq_ret_snoop.sv
module irq_ret_snoop
   import irq_chain_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fetch_i,
   input  logic [BUS_W-1:0] opcode_i,
   output logic             ret_o
);
   logic prefix_q;

   assign ret_o = fetch_i && prefix_q && (opcode_i == OPC_RETURN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prefix_q <= 1'b0;
      else if (fetch_i) prefix_q <= (opcode_i == OPC_PREFIX);
   end
endmodule

// File: rtl/irq_chain_responder.sv
module irq_chain_responder
   import irq_chain_pkg::*;
#(
   parameter int unsigned NUM_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] req_i,
   input  logic              vec_we_i,
   input  logic [7:0]        vec_wdata_i,
   input  logic              ie_i,
   output logic              ie_o,
   output logic              int_n_o,
   input  logic              m1_n_i,
   input  logic              iorq_n_i,
   input  logic [7:0]        data_i,
   output logic [7:0]        data_o,
   output logic              data_oe_o
);
   localparam int unsigned CW = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam logic [BUS_W-1:0] BASE_MASK = ~BUS_W'((1 << (CW + 1)) - 1);

   if (NUM_CH < 2 || NUM_CH > 4) begin : g_bad_ch
      $error("irq_chain_responder: NUM_CH must be 2..4");
   end
   if (BUS_W != 8) begin : g_bad_bus
      $error("irq_chain_responder: bus width must be 8");
   end

   logic [NUM_CH-1:0] pend, svc, elig, grant, done_v;
   logic [CW-1:0]     win_idx, resp_idx_q, out_idx;
   logic [CW-1:0]     svc_idx;
   logic              win_any, svc_any;
   logic [NUM_CH-1:0] win_oh;
   logic [BUS_W-1:0]  vec_q;
   logic              ack, ack_q, ack_start, fetch, fetch_q, fetch_start;
   logic              resp_now, resp_q, ret;

   assign ack         = !m1_n_i && !iorq_n_i;
   assign fetch       = !m1_n_i &&  iorq_n_i;
   assign ack_start   = ack && !ack_q;
   assign fetch_start = fetch && !fetch_q;

   always_comb begin
      logic blk;
      blk = 1'b0;
      for (int i = 0; i < NUM_CH; i++) begin
         blk     = blk | svc[i];
         elig[i] = pend[i] && !blk;
      end
   end

   irq_prio_pick #(.N(NUM_CH), .IW(CW)) u_win (
      .cand_i(elig), .any_o(win_any), .idx_o(win_idx), .onehot_o(win_oh)
   );

   logic [NUM_CH-1:0] svc_oh;
   irq_prio_pick #(.N(NUM_CH), .IW(CW)) u_svc (
      .cand_i(svc), .any_o(svc_any), .idx_o(svc_idx), .onehot_o(svc_oh)
   );

   irq_ret_snoop u_ret (
      .clk(clk), .rst_n(rst_n), .fetch_i(fetch_start), .opcode_i(data_i), .ret_o(ret)
   );

   assign grant  = (ack_start && ie_i && win_any) ? win_oh : '0;
   assign done_v = ret ? svc_oh : '0;

   irq_chan_track #(.N(NUM_CH)) u_track (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .grant_i(grant),
      .done_i(done_v), .pend_o(pend), .svc_o(svc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ack_q      <= 1'b0;
         fetch_q    <= 1'b0;
         resp_q     <= 1'b0;
         resp_idx_q <= '0;
         vec_q      <= '0;
      end else begin
         ack_q   <= ack;
         fetch_q <= fetch;
         if (vec_we_i) vec_q <= vec_wdata_i;
         if (!ack) begin
            resp_q <= 1'b0;
         end else if (ack_start) begin
            resp_q     <= ie_i && win_any;
            resp_idx_q <= win_idx;
         end
      end
   end

   assign resp_now  = ack && (ack_start ? (ie_i && win_any) : resp_q);
   assign out_idx   = ack_start ? win_idx : resp_idx_q;
   assign data_oe_o = resp_now;
   assign data_o    = (vec_q & BASE_MASK) | BUS_W'({out_idx, 1'b0});
   assign int_n_o   = !(ie_i && win_any);
   assign ie_o      = ie_i && !svc_any && (ack ? !resp_now : !(|pend));
endmodule

// File: rtl/irq_chain_checker.sv
module irq_chain_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       ie_i,
   input logic       ie_o,
   input logic       int_n_o,
   input logic       m1_n_i,
   input logic       iorq_n_i,
   input logic [7:0] data_o,
   input logic       data_oe_o
);
   // R2: a muted device neither requests nor passes the enable on
   p_muted_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !ie_i |-> (int_n_o && !ie_o && !data_oe_o));

   // R4: the vector is driven only inside an acknowledge cycle
   p_drive_in_ack_r4: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe_o |-> (!m1_n_i && !iorq_n_i));

   // R5: bit 0 of every vector is zero
   p_vec_bit0_r5: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe_o |-> (data_o[0] == 1'b0));

   // R6: a responding device keeps the chain muted
   p_resp_mutes_r6: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe_o |-> !ie_o);

   // R7: the acknowledged channel goes into service, so the chain stays muted
   p_svc_after_ack_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (data_oe_o && !(!m1_n_i && iorq_n_i)) |=> !ie_o);
endmodule

bind irq_chain_responder irq_chain_checker u_irq_chain_checker (
   .clk(clk), .rst_n(rst_n), .ie_i(ie_i), .ie_o(ie_o), .int_n_o(int_n_o),
   .m1_n_i(m1_n_i), .iorq_n_i(iorq_n_i), .data_o(data_o), .data_oe_o(data_oe_o)
);

// File: tb/test_irq_chain_responder.sv
`timescale 1ns/1ps
module test_irq_chain_responder;
   localparam int NUM_CH = 4;
   localparam real HALF = 2.5;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NUM_CH-1:0] req_i = '0;
   logic              vec_we_i = 1'b0;
   logic [7:0]        vec_wdata_i = '0;
   logic              ie_i = 1'b1;
   logic              ie_o, int_n_o, data_oe_o;
   logic              m1_n_i = 1'b1, iorq_n_i = 1'b1;
   logic [7:0]        data_i = '0;
   logic [7:0]        data_o;

   int checks = 0;
   int errors = 0;
   logic [7:0] exp_q[$];
   logic [7:0] vec_byte = 8'h00;

   always #(HALF) clk = ~clk;

   irq_chain_responder #(.NUM_CH(NUM_CH)) i_irq_chain_responder (
      .clk(clk), .rst_n(rst_n), .req_i(req_i), .vec_we_i(vec_we_i),
      .vec_wdata_i(vec_wdata_i), .ie_i(ie_i), .ie_o(ie_o), .int_n_o(int_n_o),
      .m1_n_i(m1_n_i), .iorq_n_i(iorq_n_i), .data_i(data_i), .data_o(data_o),
      .data_oe_o(data_oe_o)
   );

   function automatic logic [7:0] vec_of(logic [7:0] b, int ch);
      return {b[7:3], 2'(ch), 1'b0};
   endfunction

   task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // drives and checks happen 1 ns after the falling edge
   task automatic tick;
      @(negedge clk); #1;
   endtask

   task automatic pulse_req(logic [NUM_CH-1:0] m);
      req_i = m; tick; req_i = '0;
   endtask

   task automatic ack_cycle(bit expect_resp, int ch);
      if (expect_resp) exp_q.push_back(vec_of(vec_byte, ch));
      m1_n_i = 1'b0; iorq_n_i = 1'b0; tick;
      m1_n_i = 1'b1; iorq_n_i = 1'b1; tick;
   endtask

   task automatic fetch(logic [7:0] op);
      m1_n_i = 1'b0; iorq_n_i = 1'b1; data_i = op; tick;
      m1_n_i = 1'b1; data_i = 8'h00; tick;
   endtask

   task automatic ret_seq;
      fetch(8'hED); fetch(8'h4D);
   endtask

   task automatic write_vec(logic [7:0] b);
      vec_we_i = 1'b1; vec_wdata_i = b; tick; vec_we_i = 1'b0;
      vec_byte = b;
   endtask

   // monitor: compares each driven vector with the scoreboard (R1 R4 R5)
   always begin
      @(negedge clk); #2;
      if (rst_n && data_oe_o) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R4 unexpected vector actual=%h expected=none", data_o);
         end else begin
            chk("R5 vector", data_o, exp_q.pop_front());
         end
      end
   end

   initial begin
      #(HALF * 2 * 150000);
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      tick; tick;
      // R12 reset state
      chk("R12 int_n", {7'b0, int_n_o}, 8'h01);
      chk("R12 oe", {7'b0, data_oe_o}, 8'h00);
      rst_n = 1'b1; tick;
      chk("R12 ie_o", {7'b0, ie_o}, 8'h01);
      // R12/R11: vector byte resets to zero
      pulse_req(4'b0001);
      ack_cycle(1, 0);
      ret_seq;
      write_vec(8'h38);

      // R3 R6: one pending channel
      pulse_req(4'b1000);
      chk("R3 int_n low", {7'b0, int_n_o}, 8'h00);
      chk("R6 ie_o pending", {7'b0, ie_o}, 8'h00);
      ack_cycle(1, 3);                 // R5: 0x3E
      chk("R7 int_n after ack", {7'b0, int_n_o}, 8'h01);
      chk("R6 ie_o in service", {7'b0, ie_o}, 8'h00);
      ret_seq;
      chk("R9 ie_o after return", {7'b0, ie_o}, 8'h01);

      // R1 R7 R8: priority, blocking and nesting
      pulse_req(4'b0110);
      ack_cycle(1, 1);                 // R1
      chk("R7 ch2 blocked", {7'b0, int_n_o}, 8'h01);
      pulse_req(4'b0001);
      chk("R8 ch0 nests", {7'b0, int_n_o}, 8'h00);
      ack_cycle(1, 0);
      ret_seq;                         // ends ch0
      chk("R9 ch1 still blocks", {7'b0, int_n_o}, 8'h01);
      chk("R9 ie_o low", {7'b0, ie_o}, 8'h00);
      ret_seq;                         // ends ch1
      chk("R9 ch2 released", {7'b0, int_n_o}, 8'h00);
      ack_cycle(1, 2);
      ret_seq;
      chk("R9 all clear", {7'b0, ie_o}, 8'h01);

      // R10: broken return pair
      pulse_req(4'b0001);
      ack_cycle(1, 0);
      fetch(8'hED); fetch(8'h00); fetch(8'h4D);
      chk("R10 not cleared", {7'b0, ie_o}, 8'h00);
      ret_seq;
      chk("R10 real return", {7'b0, ie_o}, 8'h01);

      // R2: enable-in low
      ie_i = 1'b0;
      pulse_req(4'b0100);
      chk("R2 int_n muted", {7'b0, int_n_o}, 8'h01);
      chk("R2 ie_o low", {7'b0, ie_o}, 8'h00);
      ack_cycle(0, 0);
      ie_i = 1'b1; tick;
      chk("R2 int_n resumes", {7'b0, int_n_o}, 8'h00);
      ack_cycle(1, 2);
      ret_seq;

      // R4: acknowledge with nothing pending gets no vector
      ack_cycle(0, 0);
      chk("R4 oe idle", {7'b0, data_oe_o}, 8'h00);

      // R11: new vector, low bits discarded
      write_vec(8'hA9);
      pulse_req(4'b0010);
      ack_cycle(1, 1);                 // 0xAA
      ret_seq;
      tick; tick;
      chk("R4 all vectors seen", 8'(exp_q.size()), 8'h00);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule